// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block maps 32-bit virtual addresses onto 32-bit physical addresses for 4 KB pages. It holds a small table of page-to-frame mappings. Each incoming page number is compared against every valid slot at the same time, so a mapping may sit in any slot. The low 12 offset bits are never translated. They are appended unchanged to the frame number of the matching slot. The result appears on a registered response one cycle after the request is accepted.

When no slot matches, the block does not walk any table itself. It returns a response flagged as a translation exception and stops accepting lookups. The surrounding software or microcode then installs the missing mapping through the refill port. A refill goes to the slot that already holds the same page, or to the lowest-numbered empty slot, or, when the table is full, to the slot named by a round-robin victim pointer. This is a crude stand-in for least-recently-used replacement. A single flush input empties the whole table in one cycle.

Control is a two-state machine. In `ST_READY` lookups are accepted. Transition `T_MISS` goes from `ST_READY` to `ST_STALL` when an accepted lookup finds no match. In `ST_STALL` no lookups are accepted. Transition `T_REFILL` goes from `ST_STALL` back to `ST_READY` on an accepted refill.

Top module: `xlate_buffer`

## Requirements
- R1: After reset every slot is invalid, `lk_ready` is 1 and `rsp_valid` is 0. The first lookup therefore misses.
- R2: A lookup accepted in cycle t (`lk_req` and `lk_ready` both high) produces `rsp_valid` in cycle t+1. On a hit, `rsp_miss_exc` is 0 and `rsp_paddr` is the stored 20-bit frame number in bits 31:12, with `lk_vaddr[11:0]` from cycle t in bits 11:0.
- R3: On a miss, the response has `rsp_miss_exc` = 1 and `rsp_paddr` = 0. `lk_ready` is 0 from the response cycle until an accepted refill, and returns to 1 in the cycle after that refill.
- R4: Any 16 distinct page numbers can be resident at once, each in any slot, and every one of them hits.
- R5: A refill whose page is not resident goes to the lowest-numbered invalid slot when one exists.
- R6: When all 16 slots are valid, a refill of a non-resident page replaces the slot named by a victim pointer. The pointer is 0 after reset, is not changed by flush, and advances by one (modulo 16) on every accepted refill.
- R7: A refill of a page that is already resident overwrites that slot's frame number, and leaves every other mapping intact.
- R8: When a lookup and a refill occur in the same cycle, the lookup is answered from the table contents before the refill.
- R9: `flush_all` invalidates every slot in one cycle, so lookups from the next cycle on miss. A refill presented in the same cycle as `flush_all` is dropped and does not move the victim pointer.
- R10: A lookup request made while `lk_ready` is 0 is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_ready | output | 1 | Lookups are accepted (state `ST_READY`) |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_paddr | output | 32 | Translated physical address, 0 on a miss |
| rsp_miss_exc | output | 1 | Translation exception: no slot matched |
| fill_en | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Frame number to install |
| flush_all | input | 1 | Invalidate every slot |

## Verification
A corrupted slot shows up as a wrong frame number or a false exception on the very next lookup of that page. A victim pointer that skips or sticks only shows once the table is full. At that point the bench looks up each page after every replacing refill, and the wrong eviction appears as an unexpected miss within a few lookups. A state machine stuck in `ST_STALL`, or leaving it early, shows on `lk_ready` in the cycle after the refill or in the response cycle of the miss. Lookups issued during the stall catch any response they wrongly produce.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_STALL = 1'b1
    } xb_state_e;

endpackage

// File: rtl/xlate_cam.sv
module xlate_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] wr_match,
    output logic               hit,
    output logic [PFN_W-1:0]   hit_pfn
);

    logic [VPN_W-1:0] vpn_q [ENTRIES];
    logic [PFN_W-1:0] pfn_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_vec[i] <= 1'b0;
                vpn_q[i]     <= '0;
                pfn_q[i]     <= '0;
            end else if (flush) begin
                valid_vec[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                valid_vec[i] <= 1'b1;
                vpn_q[i]     <= wr_vpn;
                pfn_q[i]     <= wr_pfn;
            end
        end

        assign lk_match[i] = valid_vec[i] && (vpn_q[i] == lk_vpn);
        assign wr_match[i] = valid_vec[i] && (vpn_q[i] == wr_vpn);
    end

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) hit_pfn = hit_pfn | pfn_q[i];
        end
    end

    assign hit = |lk_match;

    // R4: a resident page must never occupy two slots
    p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R9: flush empties the table in one cycle
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_go,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    output logic [IDX_W-1:0]   slot
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] dup_idx;
    logic             have_free;
    logic             have_dup;

    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        dup_idx   = '0;
        have_dup  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx  = IDX_W'(i);
                have_free = 1'b1;
            end
            if (dup_vec[i]) begin
                dup_idx  = IDX_W'(i);
                have_dup = 1'b1;
            end
        end
    end

    always_comb begin
        if (have_dup)       slot = dup_idx;
        else if (have_free) slot = free_idx;
        else                slot = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_go) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R5: a new page lands in a free slot while one exists
    p_free_slot_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !(|dup_vec) && !(&valid_vec)) |-> !valid_vec[slot]);

    // R7: a resident page is rewritten in place
    p_dup_in_place_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && (|dup_vec)) |-> dup_vec[slot]);

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import xlate_pkg::*;
#(
    parameter int PFN_W  = 20,
    parameter int OFF_W  = 12,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [OFF_W-1:0] lk_off,
    input  logic             hit,
    input  logic [PFN_W-1:0] hit_pfn,
    input  logic             fill_go,
    output logic             lk_ready,
    output logic             rsp_valid,
    output logic             rsp_miss,
    output logic [PA_W-1:0]  rsp_paddr
);

    xb_state_e state_q, state_d;
    logic      accept;

    assign lk_ready = (state_q == ST_READY);
    assign accept   = lk_req && lk_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (accept && !hit) state_d = ST_STALL;  // T_MISS
            ST_STALL: if (fill_go)        state_d = ST_READY;  // T_REFILL
            default:                      state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_miss  <= accept && !hit;
            rsp_paddr <= (accept && hit) ? {hit_pfn, lk_off} : '0;
        end
    end

    // R3: a miss response coincides with the stall
    p_miss_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> !lk_ready);

    // R10: a request refused while stalled yields no response
    p_stall_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |=> !rsp_valid);

    // R2: each response answers an accepted request one cycle earlier
    p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_req && lk_ready));

endmodule

// File: rtl/xlate_buffer.sv
module xlate_buffer #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PFN_W   = 20,
    parameter int ENTRIES = 16,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_ready,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_miss_exc,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             flush_all
);

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wr_match;
    logic               hit;
    logic [PFN_W-1:0]   hit_pfn;
    logic [IDX_W-1:0]   wr_idx;
    logic               fill_go;

    assign fill_go = fill_en && !flush_all;

    xlate_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_all),
        .wr_en     (fill_go),
        .wr_idx    (wr_idx),
        .wr_vpn    (fill_vpn),
        .wr_pfn    (fill_pfn),
        .lk_vpn    (lk_vaddr[VA_W-1:OFF_W]),
        .valid_vec (valid_vec),
        .lk_match  (lk_match),
        .wr_match  (wr_match),
        .hit       (hit),
        .hit_pfn   (hit_pfn)
    );

    xlate_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_go   (fill_go),
        .valid_vec (valid_vec),
        .dup_vec   (wr_match),
        .slot      (wr_idx)
    );

    xlate_ctrl #(
        .PFN_W (PFN_W),
        .OFF_W (OFF_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_req    (lk_req),
        .lk_off    (lk_vaddr[OFF_W-1:0]),
        .hit       (hit),
        .hit_pfn   (hit_pfn),
        .fill_go   (fill_go),
        .lk_ready  (lk_ready),
        .rsp_valid (rsp_valid),
        .rsp_miss  (rsp_miss_exc),
        .rsp_paddr (rsp_paddr)
    );

    // R2: the page offset passes through untranslated
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss_exc) |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R3: a miss carries no address
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss_exc) |-> (rsp_paddr == '0));

endmodule

// File: tb/tb_xlate_buffer.sv
module tb_xlate_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_ready;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_miss_exc;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        flush_all = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] q_pa[$];
    logic        q_miss[$];
    string       q_tag[$];

    bit          m_val[16];
    logic [19:0] m_vpn[16];
    logic [19:0] m_pfn[16];
    int          m_ptr = 0;

    always #10 clk = ~clk;

    xlate_buffer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_req       (lk_req),
        .lk_vaddr     (lk_vaddr),
        .lk_ready     (lk_ready),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_miss_exc (rsp_miss_exc),
        .fill_en      (fill_en),
        .fill_vpn     (fill_vpn),
        .fill_pfn     (fill_pfn),
        .flush_all    (flush_all)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_pa.size() == 0) begin
                check(1'b0, "R10 unexpected response", rsp_paddr, 32'h0);
            end else begin
                logic [31:0] epa;
                logic        emiss;
                string       etag;
                epa   = q_pa.pop_front();
                emiss = q_miss.pop_front();
                etag  = q_tag.pop_front();
                check(rsp_miss_exc == emiss, {etag, " miss flag"}, {31'b0, rsp_miss_exc}, {31'b0, emiss});
                check(rsp_paddr == epa, {etag, " paddr"}, rsp_paddr, epa);
            end
        end
    end

    function automatic int model_find(input logic [19:0] vpn);
        for (int i = 0; i < 16; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    task automatic model_fill(input logic [19:0] vpn, input logic [19:0] pfn);
        int s;
        s = model_find(vpn);
        if (s < 0) begin
            for (int i = 15; i >= 0; i--) if (!m_val[i]) s = i;
        end
        if (s < 0) s = m_ptr;
        m_val[s] = 1'b1;
        m_vpn[s] = vpn;
        m_pfn[s] = pfn;
        m_ptr = (m_ptr + 1) % 16;
    endtask

    task automatic push_expect(input logic [31:0] va, input string tag, output bit miss);
        int s;
        s = model_find(va[31:12]);
        miss = (s < 0);
        q_miss.push_back(miss);
        q_pa.push_back(miss ? 32'h0 : {m_pfn[s], va[11:0]});
        q_tag.push_back(miss ? "R3" : tag);
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn);
        @(negedge clk);
        fill_en  = 1'b1;
        fill_vpn = vpn;
        fill_pfn = pfn;
        model_fill(vpn, pfn);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // lookup; a miss is answered by a refill as software would
    task automatic lookup(input logic [31:0] va, input string tag);
        bit miss;
        @(negedge clk);
        lk_req   = 1'b1;
        lk_vaddr = va;
        push_expect(va, tag, miss);
        @(negedge clk);
        lk_req = 1'b0;
        if (miss) begin
            check(lk_ready == 1'b0, "R3 stall after miss", {31'b0, lk_ready}, 32'h0);
            fill_en  = 1'b1;
            fill_vpn = va[31:12];
            fill_pfn = va[31:12] ^ 20'h5A5A5;
            model_fill(va[31:12], va[31:12] ^ 20'h5A5A5);
            @(negedge clk);
            fill_en = 1'b0;
            check(lk_ready == 1'b1, "R3 ready after refill", {31'b0, lk_ready}, 32'h1);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_val[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(lk_ready == 1'b1, "R1 ready in reset", {31'b0, lk_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R1 no response in reset", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;

        // R1/R3/R10: first lookup misses; stalled requests are ignored
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = 32'h12345678;
        q_pa.push_back(32'h0); q_miss.push_back(1'b1); q_tag.push_back("R1");
        @(negedge clk);
        check(lk_ready == 1'b0, "R3 stall", {31'b0, lk_ready}, 32'h0);
        lk_vaddr = 32'hDEAD0123;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(lk_ready == 1'b0, "R10 still stalled", {31'b0, lk_ready}, 32'h0);
        end
        lk_req = 1'b0;
        fill_en = 1'b1; fill_vpn = 20'h12345; fill_pfn = 20'hABCDE;
        model_fill(20'h12345, 20'hABCDE);
        @(negedge clk);
        fill_en = 1'b0;
        check(lk_ready == 1'b1, "R3 ready after refill", {31'b0, lk_ready}, 32'h1);

        // R2: hits with different offsets, back to back
        lookup(32'h12345678, "R2");
        lookup(32'h12345000, "R2");
        lookup(32'h12345FFF, "R2");

        // R5/R4: fill the remaining slots, then all hit
        for (int i = 1; i < 16; i++) do_fill(20'h80000 ^ 20'(i * 20'h1111), 20'(i * 20'h0F0F1));
        lookup(32'h12345ABC, "R4");
        for (int i = 1; i < 16; i++) lookup({20'h80000 ^ 20'(i * 20'h1111), 12'(i * 7)}, "R4 R5");

        // R6: table full, victims follow the pointer
        do_fill(20'h00001, 20'h11111);
        do_fill(20'h00002, 20'h22222);
        lookup(32'h00001004, "R6");
        lookup(32'h00002008, "R6");
        for (int i = 2; i < 16; i++) lookup({20'h80000 ^ 20'(i * 20'h1111), 12'h010}, "R6");
        lookup(32'h12345010, "R6 evicted");
        lookup(32'h81111010, "R6 evicted");

        // R7: refill of a resident page rewrites in place
        do_fill(20'h00001, 20'h77777);
        lookup(32'h00001FFC, "R7");
        lookup(32'h00002FFC, "R7 neighbour");

        // R8: same-cycle lookup and refill sees old contents
        begin
            bit miss;
            @(negedge clk);
            lk_req = 1'b1; lk_vaddr = 32'h00002444;
            push_expect(32'h00002444, "R8 old contents", miss);
            fill_en = 1'b1; fill_vpn = 20'h00002; fill_pfn = 20'h99999;
            model_fill(20'h00002, 20'h99999);
            @(negedge clk);
            lk_req = 1'b0; fill_en = 1'b0;
        end
        lookup(32'h00002444, "R8 new contents");

        // R9: flush drops everything including a same-cycle refill
        @(negedge clk);
        flush_all = 1'b1;
        fill_en = 1'b1; fill_vpn = 20'h0CAFE; fill_pfn = 20'h0BEEF;
        for (int i = 0; i < 16; i++) m_val[i] = 1'b0;
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
        lookup(32'h00001000, "R9");
        lookup(32'h0CAFE000, "R9 dropped refill");
        lookup(32'h00001000, "R9 refilled");

        repeat (3) @(negedge clk);
        check(q_pa.size() == 0, "R2 responses outstanding", q_pa.size(), 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule